// File: doc/BRIEF.md
# GPIO Edge/Level Interrupt Unit

The unit watches 32 general-purpose input pins and turns activity on them into interrupt requests. Each pin has its own detection settings. It can fire on a level or on an edge. It can pick its active level or the edges it reacts to. It can also either latch its event or report the live condition. Software configures and services the unit through a 16-bit word register port. Pins 0–15 belong to the low-half registers and pins 16–31 to the high-half registers.

Every pin passes through a synchroniser before detection. A per-pin status bit records the detected condition. A single interrupt output goes to a cascaded interrupt controller and is active while any pin has both its status bit and its enable bit set. Software finds the source by reading status and enable. It acknowledges a latched event by writing a one to the matching status bit.

Top module: `gpio_irq_unit`

## Requirements
- R1: While rst_ni is low, every register reads 0 and irq_o is 0.
- R2: Register map (byte offsets, low/high half): status 0x08/0x0A, enable 0x0C/0x0E, type 0x10/0x12, active-level 0x14/0x16, hold 0x18/0x1A, falling-edge 0x20/0x22, rising-edge 0x24/0x26. Bit k of a high-half register belongs to pin 16+k. Configuration registers read back what was written. All other offsets read 0.
- R3: A change on a pin shows in its status bit after the third rising clock edge following the change. Status bit and irq_o are unchanged after the first two edges.
- R4: With the type bit 0 (level), the condition is "pin high" when the active-level bit is 1 and "pin low" when it is 0.
- R5: With the type bit 1 (edge), the condition is a rising edge when the rising bit is set, or a falling edge when the falling bit is set. Setting both bits detects both edges, and an edge whose bit is clear is not detected.
- R6: With the hold bit 1, a status bit stays set after its condition ends. Writing 1 to it clears it, and writing 0 leaves it unchanged. If the condition is present in the same cycle as the clearing write, the bit stays set.
- R7: With the hold bit 0, the status bit follows the condition one cycle later, so an edge gives a one-cycle status pulse. A write of 1 to the status bit does not override a condition that is still present.
- R8: irq_o is 1 exactly when some status bit and its enable bit are both 1, and it changes in the same cycle as the status bit.
- R9: Clearing an enable bit does not change the pin's status bit.
- R10: With all enable bits 0, irq_o stays 0 whatever the status bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 32 | Asynchronous input pins |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte offset, bits 5 to 1 |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data for the addressed register, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Register writes take effect at the next rising edge. Reads are combinational, so the bench drives at the falling edge and samples one nanosecond later. A pin change appears in status and in irq_o after the third rising edge, which is two synchroniser stages plus the status flop. The directed checks sample after the second edge to show nothing has changed yet, and again after the third edge to show the result. A through-mode edge is checked once more a cycle later to show the pulse has dropped. During the random phase, a bench model updates on the same edges, and every read and irq_o value is compared against it on each cycle.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
  localparam int unsigned NCFG = 6;

  // word index = byte offset >> 1
  localparam logic [4:0] W_STAT_LO = 5'h04, W_STAT_HI = 5'h05;
  localparam logic [4:0] W_EN_LO   = 5'h06, W_EN_HI   = 5'h07;
  localparam logic [4:0] W_TYP_LO  = 5'h08, W_TYP_HI  = 5'h09;
  localparam logic [4:0] W_LVL_LO  = 5'h0A, W_LVL_HI  = 5'h0B;
  localparam logic [4:0] W_HOLD_LO = 5'h0C, W_HOLD_HI = 5'h0D;
  localparam logic [4:0] W_FALL_LO = 5'h10, W_FALL_HI = 5'h11;
  localparam logic [4:0] W_RISE_LO = 5'h12, W_RISE_HI = 5'h13;

  // config fields start at FLD_EN; order defines storage layout
  typedef enum logic [2:0] {
    FLD_NONE, FLD_STAT, FLD_EN, FLD_TYP, FLD_LVL, FLD_HOLD, FLD_FALL, FLD_RISE
  } fld_e;

  typedef struct packed {
    fld_e fld;
    logic hi;
  } sel_t;

  function automatic sel_t decode(input logic [4:0] w);
    sel_t s;
    s.hi = w[0];
    unique case ({w[4:1], 1'b0})
      W_STAT_LO: s.fld = FLD_STAT;
      W_EN_LO:   s.fld = FLD_EN;
      W_TYP_LO:  s.fld = FLD_TYP;
      W_LVL_LO:  s.fld = FLD_LVL;
      W_HOLD_LO: s.fld = FLD_HOLD;
      W_FALL_LO: s.fld = FLD_FALL;
      W_RISE_LO: s.fld = FLD_RISE;
      default:   s.fld = FLD_NONE;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/gpio_irq_sync.sv
`timescale 1ns/1ps
module gpio_irq_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] p_o
);
  logic [W-1:0] st_q [STAGES];
  logic [W-1:0] p_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) st_q[k] <= '0;
      p_q <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) st_q[k] <= st_q[k-1];
      p_q <= st_q[STAGES-1];
    end
  end

  assign s_o = st_q[STAGES-1];
  assign p_o = p_q;
endmodule

// File: rtl/gpio_irq_regs.sv
`timescale 1ns/1ps
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [4:0]      waddr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [2*DW-1:0] stat_i,
  output logic [DW-1:0]   rdata_o,
  output logic [2*DW-1:0] en_o,
  output logic [2*DW-1:0] typ_o,
  output logic [2*DW-1:0] lvl_o,
  output logic [2*DW-1:0] hold_o,
  output logic [2*DW-1:0] fall_o,
  output logic [2*DW-1:0] rise_o,
  output logic [2*DW-1:0] clr_o
);
  localparam int unsigned NPIN   = 2 * DW;
  localparam int unsigned WIDX_W = $clog2(2 * NCFG);

  sel_t                 sel;
  logic [NCFG*NPIN-1:0] cfg_flat;
  logic [WIDX_W-1:0]    widx;

  assign sel = decode(waddr_i);

  for (genvar f = 0; f < NCFG; f++) begin : g_fld
    for (genvar h = 0; h < 2; h++) begin : g_half
      logic [DW-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else if (we_i && sel.fld == fld_e'(3'(f + 2)) && sel.hi == 1'(h)) q <= wdata_i;
      end
      assign cfg_flat[(f*2+h)*DW +: DW] = q;
    end
  end

  assign en_o   = cfg_flat[0*NPIN +: NPIN];
  assign typ_o  = cfg_flat[1*NPIN +: NPIN];
  assign lvl_o  = cfg_flat[2*NPIN +: NPIN];
  assign hold_o = cfg_flat[3*NPIN +: NPIN];
  assign fall_o = cfg_flat[4*NPIN +: NPIN];
  assign rise_o = cfg_flat[5*NPIN +: NPIN];

  always_comb begin
    clr_o = '0;
    if (we_i && sel.fld == FLD_STAT) begin
      if (sel.hi) clr_o[NPIN-1:DW] = wdata_i;
      else        clr_o[DW-1:0]    = wdata_i;
    end
  end

  always_comb begin
    widx = {sel.fld - 3'd2, sel.hi};
    unique case (sel.fld)
      FLD_NONE: rdata_o = '0;
      FLD_STAT: rdata_o = sel.hi ? stat_i[NPIN-1:DW] : stat_i[DW-1:0];
      default:  rdata_o = cfg_flat[widx*DW +: DW];
    endcase
  end
endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] s_i,
  input  logic [N-1:0] p_i,
  input  logic [N-1:0] typ_i,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] hold_i,
  input  logic [N-1:0] fall_i,
  input  logic [N-1:0] rise_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_o
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic rise_d, fall_d, edge_hit, lvl_hit, cond, q;

    always_comb begin
      rise_d   = s_i[i] & ~p_i[i];
      fall_d   = ~s_i[i] & p_i[i];
      edge_hit = (rise_d & rise_i[i]) | (fall_d & fall_i[i]);
      lvl_hit  = lvl_i[i] ? s_i[i] : ~s_i[i];
      cond     = typ_i[i] ? edge_hit : lvl_hit;
    end

    // new event beats a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q <= 1'b0;
      else if (hold_i[i]) q <= cond | (q & ~clr_i[i]);
      else                q <= cond;
    end

    assign stat_o[i] = q;
  end
endmodule

// File: rtl/gpio_irq_unit.sv
`timescale 1ns/1ps
module gpio_irq_unit #(
  parameter int unsigned DW          = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [2*DW-1:0] pin_i,
  input  logic            reg_we_i,
  input  logic [5:1]      reg_addr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  output logic            irq_o
);
  localparam int unsigned NPIN = 2 * DW;

  logic [NPIN-1:0] s_w, p_w, stat_w, clr_w;
  logic [NPIN-1:0] en_w, typ_w, lvl_w, hold_w, fall_w, rise_w;

  gpio_irq_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .s_o   (s_w),
    .p_o   (p_w)
  );

  gpio_irq_regs #(.DW(DW)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .waddr_i(reg_addr_i),
    .wdata_i(reg_wdata_i),
    .stat_i (stat_w),
    .rdata_o(reg_rdata_o),
    .en_o   (en_w),
    .typ_o  (typ_w),
    .lvl_o  (lvl_w),
    .hold_o (hold_w),
    .fall_o (fall_w),
    .rise_o (rise_w),
    .clr_o  (clr_w)
  );

  gpio_irq_detect #(.N(NPIN)) u_det (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .s_i   (s_w),
    .p_i   (p_w),
    .typ_i (typ_w),
    .lvl_i (lvl_w),
    .hold_i(hold_w),
    .fall_i(fall_w),
    .rise_i(rise_w),
    .clr_i (clr_w),
    .stat_o(stat_w)
  );

  assign irq_o = |(stat_w & en_w);
endmodule

// File: rtl/gpio_irq_chk.sv
`timescale 1ns/1ps
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            reg_we_i,
  input logic [5:1]      reg_addr_i,
  input logic [DW-1:0]   reg_wdata_i,
  input logic [DW-1:0]   reg_rdata_o,
  input logic            irq_o,
  input logic [2*DW-1:0] en_i,
  input logic [2*DW-1:0] hold_i,
  input logic [2*DW-1:0] stat_i,
  input logic [2*DW-1:0] clr_i
);
  sel_t sel_w;
  assign sel_w = decode(reg_addr_i);

  AST_MASK_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |-> !irq_o); // R10

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (stat_i != '0)); // R8

  AST_HOLD_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(stat_i & hold_i & ~clr_i)) |=>
      ((stat_i & $past(stat_i & hold_i & ~clr_i)) == $past(stat_i & hold_i & ~clr_i))); // R6

  AST_MASK_KEEPS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && sel_w.fld == FLD_EN) |=>
      ((stat_i & $past(stat_i & hold_i)) == $past(stat_i & hold_i))); // R9

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_w.fld == FLD_NONE) |-> (reg_rdata_o == '0)); // R2

  AST_EN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == W_EN_LO) |=> (en_i[DW-1:0] == $past(reg_wdata_i))); // R2
endmodule

bind gpio_irq_unit gpio_irq_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .irq_o      (irq_o),
  .en_i       (en_w),
  .hold_i     (hold_w),
  .stat_i     (stat_w),
  .clr_i      (clr_w)
);

// File: tb/sim_gpio_irq_unit.sv
`timescale 1ns/1ps
module sim_gpio_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin = '0;
  logic        we = 1'b0;
  logic [5:1]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  gpio_irq_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  // reference model, fields: 1 en 2 type 3 level 4 hold 5 fall 6 rise
  logic [31:0] m_s1, m_s2, m_p, m_st;
  logic [31:0] m_cfg [1:6];

  function automatic int fidx(input logic [5:0] a);
    case ({a[5:2], 2'b00})
      6'h08: return 0;
      6'h0C: return 1;
      6'h10: return 2;
      6'h14: return 3;
      6'h18: return 4;
      6'h20: return 5;
      6'h24: return 6;
      default: return -1;
    endcase
  endfunction

  function automatic logic [15:0] m_read(input logic [5:0] a);
    int f = fidx(a);
    logic [31:0] v;
    if (f < 0) return 16'h0;
    v = (f == 0) ? m_st : m_cfg[f];
    return a[1] ? v[31:16] : v[15:0];
  endfunction

  function automatic logic [31:0] m_next();
    logic [31:0] n, clr;
    logic r, fl, c;
    logic [5:0] a = {addr, 1'b0};
    clr = '0;
    if (we && fidx(a) == 0) clr = a[1] ? {wdata, 16'h0} : {16'h0, wdata};
    for (int i = 0; i < 32; i++) begin
      r  = m_s2[i] & ~m_p[i];
      fl = ~m_s2[i] & m_p[i];
      c  = m_cfg[2][i] ? ((r & m_cfg[6][i]) | (fl & m_cfg[5][i]))
                       : (m_cfg[3][i] ? m_s2[i] : ~m_s2[i]);
      n[i] = m_cfg[4][i] ? (c | (m_st[i] & ~clr[i])) : c;
    end
    return n;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_p <= '0; m_st <= '0;
      for (int f = 1; f <= 6; f++) m_cfg[f] <= '0;
    end else begin
      m_s1 <= pin; m_s2 <= m_s1; m_p <= m_s2;
      m_st <= m_next();
      if (we && fidx({addr, 1'b0}) > 0) begin
        if (addr[1]) m_cfg[fidx({addr, 1'b0})][31:16] <= wdata;
        else         m_cfg[fidx({addr, 1'b0})][15:0]  <= wdata;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, input logic [15:0] e, input string tag);
    addr = a[5:1];
    #1;
    chk(tag, {16'h0, rdata}, {16'h0, e});
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    we = 1'b1; addr = a[5:1]; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [5:0] pick_off(input int k);
    case (k)
      0: return 6'h08;  1: return 6'h0A;  2: return 6'h0C;  3: return 6'h0E;
      4: return 6'h10;  5: return 6'h12;  6: return 6'h14;  7: return 6'h16;
      8: return 6'h18;  9: return 6'h1A; 10: return 6'h20; 11: return 6'h22;
      12: return 6'h24; default: return 6'h26;
    endcase
  endfunction

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    step(2);
    rd(6'h08, 16'h0, "R1 status in reset");
    rd(6'h14, 16'h0, "R1 level in reset");
    chk("R1 irq in reset", {31'h0, irq}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    step(1);
    rd(6'h08, 16'hFFFF, "R4 active-low level lo");
    rd(6'h0A, 16'hFFFF, "R4 active-low level hi");
    chk("R10 no enable no irq", {31'h0, irq}, 32'h0);
    wr(6'h14, 16'hFFFF); wr(6'h16, 16'hFFFF); step(1);
    rd(6'h08, 16'h0, "R4 active-high lo");
    rd(6'h0A, 16'h0, "R4 active-high hi");
    // latency, level through
    wr(6'h0C, 16'h0008);
    pin[3] = 1'b1;
    step(2);
    rd(6'h08, 16'h0, "R3 status after two edges");
    chk("R3 irq after two edges", {31'h0, irq}, 32'h0);
    step(1);
    rd(6'h08, 16'h0008, "R3 status after three edges");
    chk("R8 irq with status and enable", {31'h0, irq}, 32'h1);
    wr(6'h08, 16'h0008);
    rd(6'h08, 16'h0008, "R7 clear ignored while condition holds");
    pin[3] = 1'b0; step(3);
    rd(6'h08, 16'h0, "R7 status follows condition");
    // hold
    wr(6'h18, 16'h0008);
    pin[3] = 1'b1; step(1); pin[3] = 1'b0; step(4);
    rd(6'h08, 16'h0008, "R6 pulse latched");
    rd(6'h19, 16'h0008, "R2 hold readback");
    wr(6'h08, 16'h0000);
    rd(6'h08, 16'h0008, "R6 write zero no effect");
    wr(6'h0C, 16'h0000);
    rd(6'h08, 16'h0008, "R9 mask keeps status");
    chk("R10 masked irq", {31'h0, irq}, 32'h0);
    wr(6'h08, 16'h0008);
    rd(6'h08, 16'h0, "R6 write one clears");
    pin[3] = 1'b1; step(3);
    wr(6'h08, 16'h0008);
    rd(6'h08, 16'h0008, "R6 event wins over clear");
    pin[3] = 1'b0; step(3); wr(6'h08, 16'h0008);
    rd(6'h08, 16'h0, "R6 clear after condition gone");
    // edges on pin 20 = high bit 4
    wr(6'h12, 16'h0010); wr(6'h1A, 16'h0010); wr(6'h26, 16'h0010); wr(6'h0E, 16'h0010);
    rd(6'h0A, 16'h0, "R5 edge idle");
    pin[20] = 1'b1; step(2);
    rd(6'h0A, 16'h0, "R3 edge after two edges");
    step(1);
    rd(6'h0A, 16'h0010, "R5 rising detected, R2 high mapping");
    chk("R8 irq from high half", {31'h0, irq}, 32'h1);
    wr(6'h0A, 16'h0010);
    pin[20] = 1'b0; step(4);
    rd(6'h0A, 16'h0, "R5 falling ignored when disabled");
    chk("R8 irq low after clear", {31'h0, irq}, 32'h0);
    wr(6'h26, 16'h0000); wr(6'h22, 16'h0010);
    pin[20] = 1'b1; step(4);
    rd(6'h0A, 16'h0, "R5 rising ignored when disabled");
    pin[20] = 1'b0; step(4);
    rd(6'h0A, 16'h0010, "R5 falling detected");
    wr(6'h0A, 16'h0010);
    wr(6'h26, 16'h0010);
    pin[20] = 1'b1; step(4);
    rd(6'h0A, 16'h0010, "R5 both edges rise");
    wr(6'h0A, 16'h0010);
    pin[20] = 1'b0; step(4);
    rd(6'h0A, 16'h0010, "R5 both edges fall");
    wr(6'h0A, 16'h0010);
    wr(6'h1A, 16'h0000);
    pin[20] = 1'b1; step(3);
    rd(6'h0A, 16'h0010, "R7 edge pulse high");
    step(1);
    rd(6'h0A, 16'h0, "R7 edge pulse one cycle");
    rd(6'h22, 16'h0010, "R2 falling readback");
    rd(6'h00, 16'h0, "R2 unmapped 0x00");
    rd(6'h04, 16'h0, "R2 unmapped 0x04");
    rd(6'h1C, 16'h0, "R2 unmapped 0x1C");
    rd(6'h1E, 16'h0, "R2 unmapped 0x1E");
    rd(6'h28, 16'h0, "R2 unmapped 0x28");
    rd(6'h3E, 16'h0, "R2 unmapped 0x3E");
    // random phase against model
    for (int n = 0; n < 4000; n++) begin
      logic [5:0] a;
      @(negedge clk);
      pin = pin ^ ($urandom & $urandom & $urandom);
      we = ($urandom % 4) == 0;
      a = (($urandom % 4) != 0) ? pick_off(int'($urandom % 14)) : 6'($urandom);
      addr = a[5:1];
      wdata = 16'($urandom);
      #1;
      chk("R2 random read", {16'h0, rdata}, {16'h0, m_read({addr, 1'b0})});
      chk("R8 random irq", {31'h0, irq}, {31'h0, |(m_st & m_cfg[1])});
    end
    @(negedge clk); we = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule